// File: doc/BRIEF.md
# APB Ready Timeout Monitor

The monitor sits between an APB bridge and nine downstream APB slaves. The bridge's address decoder gives it a one-hot select vector. When an access phase toward a slave waits on that slave's ready, the monitor counts the stalled APB clocks. If the count reaches a programmable limit, the monitor completes the transfer toward the master by itself and reports an error response. It also records which slave stalled in a sticky flag bit.

Software reaches two registers through a separate zero-wait APB register port. The limit register holds a 20-bit count of APB clocks. The flag register holds one write-1-to-clear bit per slave. In normal operation the selected slave's ready and error reach the master unchanged. The monitor alters the response only when a timeout fires.

Top module: `apb_stall_guard`

## Requirements
- R1: After reset the limit register reads 0x000FF and the flag register reads 0.
- R2: Register map on the 4-bit register address: offset 0x0 is the limit in bits 19:0, offset 0x4 is the flags in bits 8:0. All other bits and all other offsets read 0, and limit write data above bit 19 is dropped. A register write takes effect when select, enable and write are all high in one cycle.
- R3: While no timeout fires, the master's ready and error equal the ready and error of the slave whose select bit is set.
- R4: With limit T not 0, an access phase whose slave stays not-ready is completed by the monitor in its (T+1)-th cycle, after T stalled cycles, with ready and error both high. From the next cycle the flag bit whose index equals the selected slave's index reads 1.
- R5: If the slave raises ready in the cycle where the timeout would fire, the slave's ready and error reach the master and no flag is set.
- R6: A limit of 0 disables detection: no stall, however long, is completed or flagged by the monitor.
- R7: Flags are sticky. Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R8: If a timeout sets a flag in the same cycle that software writes 1 to that bit, the bit ends up set.
- R9: The stall count restarts at every completed transfer, so each new access gets a full window, including back-to-back accesses.
- R10: If software lowers the limit to or below the stall count already reached, the monitor completes the access in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | APB clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 9 | One-hot slave select from the bridge |
| penable_i | input | 1 | Access-phase enable from the bridge |
| slv_ready_i | input | 9 | Ready from each slave |
| slv_err_i | input | 9 | Error response from each slave |
| mst_ready_o | output | 1 | Ready returned to the bridge |
| mst_err_o | output | 1 | Error returned to the bridge |
| cfg_psel_i | input | 1 | Register port select |
| cfg_penable_i | input | 1 | Register port enable |
| cfg_pwrite_i | input | 1 | Register port write strobe |
| cfg_paddr_i | input | 4 | Register port byte address |
| cfg_pwdata_i | input | 32 | Register port write data |
| cfg_prdata_o | output | 32 | Register port read data |

## Verification
A stall counter that drifts by one cycle shows at the master port within one transfer: ready rises a cycle early or late against the limit, and the error response appears where none was due. A corrupted flag or limit register is only visible on a register read or at the next timeout. For that reason the flag and limit registers are read back after every scenario that can change them. Every cycle, the bench compares ready, error and read data against its own stall model, so a fault shows up in the cycle where it first changes the response.

// File: rtl/apb_stall_guard.sv
module apb_stall_guard #(
  parameter int N_SLV     = 9,
  parameter int CNT_W     = 20,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int THR_RST   = 'hFF,
  parameter int LIM_ADDR  = 'h0,
  parameter int FLAG_ADDR = 'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SLV-1:0]  sel_i,
  input  logic              penable_i,
  input  logic [N_SLV-1:0]  slv_ready_i,
  input  logic [N_SLV-1:0]  slv_err_i,
  output logic              mst_ready_o,
  output logic              mst_err_o,
  input  logic              cfg_psel_i,
  input  logic              cfg_penable_i,
  input  logic              cfg_pwrite_i,
  input  logic [ADDR_W-1:0] cfg_paddr_i,
  input  logic [DATA_W-1:0] cfg_pwdata_i,
  output logic [DATA_W-1:0] cfg_prdata_o
);
  localparam int LIM_PAD  = DATA_W - CNT_W;
  localparam int FLAG_PAD = DATA_W - N_SLV;

  logic [CNT_W-1:0] lim_q, stall_q;
  logic [N_SLV-1:0] flag_q;
  logic             in_access, slv_done, slv_fail, expire, wr_en;
  logic             unused_wdata;

  assign in_access = penable_i && (|sel_i);
  assign slv_done  = |(sel_i & slv_ready_i);
  assign slv_fail  = |(sel_i & slv_err_i);
  assign expire    = in_access && !slv_done && (lim_q != '0) && (stall_q >= lim_q);

  assign mst_ready_o = slv_done || expire;
  assign mst_err_o   = slv_done ? slv_fail : expire;

  assign wr_en = cfg_psel_i && cfg_penable_i && cfg_pwrite_i;
  assign unused_wdata = ^cfg_pwdata_i[DATA_W-1:CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stall_q <= '0;
    else if (in_access && !slv_done && !expire)
      stall_q <= stall_q + 1'b1;
    else
      stall_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lim_q <= CNT_W'(THR_RST);
    else if (wr_en && cfg_paddr_i == ADDR_W'(LIM_ADDR))
      lim_q <= cfg_pwdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= '0;
    else begin
      logic [N_SLV-1:0] clr;
      clr = (wr_en && cfg_paddr_i == ADDR_W'(FLAG_ADDR)) ? cfg_pwdata_i[N_SLV-1:0] : '0;
      flag_q <= (flag_q & ~clr) | (expire ? sel_i : '0);
    end
  end

  always_comb begin
    if (cfg_paddr_i == ADDR_W'(LIM_ADDR))
      cfg_prdata_o = {{LIM_PAD{1'b0}}, lim_q};
    else if (cfg_paddr_i == ADDR_W'(FLAG_ADDR))
      cfg_prdata_o = {{FLAG_PAD{1'b0}}, flag_q};
    else
      cfg_prdata_o = '0;
  end
endmodule

module apb_stall_guard_chk #(
  parameter int N_SLV     = 9,
  parameter int CNT_W     = 20,
  parameter int ADDR_W    = 4,
  parameter int FLAG_ADDR = 'h4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SLV-1:0]  sel_i,
  input logic              penable_i,
  input logic [N_SLV-1:0]  slv_ready_i,
  input logic              mst_ready_o,
  input logic              mst_err_o,
  input logic              cfg_psel_i,
  input logic              cfg_penable_i,
  input logic              cfg_pwrite_i,
  input logic [ADDR_W-1:0] cfg_paddr_i,
  input logic [CNT_W-1:0]  lim_q,
  input logic [N_SLV-1:0]  flag_q
);
  logic flag_wr, forced;
  assign flag_wr = cfg_psel_i && cfg_penable_i && cfg_pwrite_i && cfg_paddr_i == ADDR_W'(FLAG_ADDR);
  assign forced  = penable_i && (|sel_i) && mst_ready_o && !(|(sel_i & slv_ready_i));

  assert_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel_i));

  assert_forced_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
    forced |-> mst_err_o);

  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    forced |=> ((flag_q & $past(sel_i)) == $past(sel_i)));

  assert_slave_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (penable_i && (|(sel_i & slv_ready_i)) && !flag_wr) |=> (flag_q == $past(flag_q)));

  assert_disabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_q == '0) |-> !forced);

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

bind apb_stall_guard apb_stall_guard_chk #(
  .N_SLV(N_SLV), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .FLAG_ADDR(FLAG_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .penable_i(penable_i),
  .slv_ready_i(slv_ready_i), .mst_ready_o(mst_ready_o), .mst_err_o(mst_err_o),
  .cfg_psel_i(cfg_psel_i), .cfg_penable_i(cfg_penable_i), .cfg_pwrite_i(cfg_pwrite_i),
  .cfg_paddr_i(cfg_paddr_i), .lim_q(lim_q), .flag_q(flag_q)
);

// File: tb/tb_apb_stall_guard.sv
module tb_apb_stall_guard;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [8:0]  sel = '0;
  logic        pen = 1'b0;
  logic [8:0]  rdy = '0;
  logic [8:0]  err = '0;
  logic        mst_ready, mst_err;
  logic        c_sel = 1'b0, c_en = 1'b0, c_wr = 1'b0;
  logic [3:0]  c_addr = '0;
  logic [31:0] c_wdata = '0;
  logic [31:0] c_rdata;

  int tests = 0, fails = 0;
  string req = "R1";

  int          m_lim = 'hFF;
  int          m_stall = 0;
  logic [8:0]  m_flags = '0;
  bit          last_done;

  always #2 clk = ~clk;

  apb_stall_guard dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .penable_i(pen),
    .slv_ready_i(rdy), .slv_err_i(err), .mst_ready_o(mst_ready), .mst_err_o(mst_err),
    .cfg_psel_i(c_sel), .cfg_penable_i(c_en), .cfg_pwrite_i(c_wr),
    .cfg_paddr_i(c_addr), .cfg_pwdata_i(c_wdata), .cfg_prdata_o(c_rdata)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: compare outputs with the model, then advance the model
  task automatic cyc();
    bit act, sdone, sfail, fire, e_rdy, e_err, fwr;
    logic [31:0] e_rd;
    #1;
    act   = pen && (sel != 0);
    sdone = |(sel & rdy);
    sfail = |(sel & err);
    fire  = act && !sdone && m_lim != 0 && m_stall >= m_lim;
    e_rdy = sdone || fire;
    e_err = sdone ? sfail : fire;
    check({req, " ready"}, {31'd0, mst_ready}, {31'd0, e_rdy});
    check({req, " error"}, {31'd0, mst_err}, {31'd0, e_err});
    if (c_sel) begin
      e_rd = (c_addr == 4'h0) ? 32'(m_lim) : (c_addr == 4'h4) ? {23'd0, m_flags} : 32'd0;
      check({req, " rdata"}, c_rdata, e_rd);
    end
    last_done = act && e_rdy;
    @(posedge clk);
    fwr = c_sel && c_en && c_wr;
    if (act && !sdone && !fire) m_stall++; else m_stall = 0;
    if (fwr && c_addr == 4'h4) m_flags = m_flags & ~c_wdata[8:0];
    if (fire) m_flags = m_flags | sel;
    if (fwr && c_addr == 4'h0) m_lim = int'(c_wdata[19:0]);
    @(negedge clk);
  endtask

  task automatic reg_wr(logic [3:0] a, logic [31:0] d);
    c_sel = 1; c_en = 0; c_wr = 1; c_addr = a; c_wdata = d; cyc();
    c_en = 1; cyc();
    c_sel = 0; c_en = 0; c_wr = 0;
  endtask

  task automatic reg_rd(logic [3:0] a, logic [31:0] exp, string tag);
    c_sel = 1; c_en = 1; c_wr = 0; c_addr = a;
    #1 check({tag, " direct read"}, c_rdata, exp);
    cyc();
    c_sel = 0; c_en = 0;
  endtask

  // ready_after < 0: slave never answers; cfg_at >= 0: register write in that access cycle
  task automatic xfer(int idx, int ready_after, bit e, int cfg_at, logic [3:0] ca, logic [31:0] cd,
                      int exp_len, string tag);
    int len = 0;
    sel = 9'(1 << idx); pen = 0; rdy = 0; err = 0; cyc();
    pen = 1;
    for (int k = 0; k < 5000; k++) begin
      rdy = (k == ready_after) ? 9'(1 << idx) : '0;
      err = (k == ready_after && e) ? 9'(1 << idx) : '0;
      if (k == cfg_at) begin c_sel = 1; c_en = 1; c_wr = 1; c_addr = ca; c_wdata = cd; end
      else begin c_sel = 0; c_en = 0; c_wr = 0; end
      len++;
      cyc();
      if (last_done) break;
    end
    c_sel = 0; c_en = 0; c_wr = 0;
    if (exp_len > 0) check({tag, " access length"}, 32'(len), 32'(exp_len));
    sel = 0; pen = 0; rdy = 0; err = 0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    req = "R1";
    reg_rd(4'h0, 32'hFF, "R1");
    reg_rd(4'h4, 32'h0, "R1");
    req = "R2";
    reg_rd(4'h8, 32'h0, "R2");
    req = "R1";
    xfer(6, -1, 0, -1, 0, 0, 256, "R1");
    reg_wr(4'h4, 32'h1FF);

    req = "R3";
    xfer(2, 3, 0, -1, 0, 0, 4, "R3");
    xfer(5, 0, 1, -1, 0, 0, 1, "R3");
    reg_rd(4'h4, 32'h0, "R3");

    req = "R2";
    reg_wr(4'h0, 32'hFFF0_0004);
    reg_rd(4'h0, 32'h4, "R2");

    req = "R4";
    xfer(7, -1, 0, -1, 0, 0, 5, "R4");
    reg_rd(4'h4, 32'h080, "R4");

    req = "R5";
    xfer(1, 4, 0, -1, 0, 0, 5, "R5");
    xfer(4, 4, 1, -1, 0, 0, 5, "R5");
    reg_rd(4'h4, 32'h080, "R5");

    req = "R9";
    xfer(0, -1, 0, -1, 0, 0, 5, "R9");
    xfer(8, -1, 0, -1, 0, 0, 5, "R9");
    reg_rd(4'h4, 32'h181, "R9");

    req = "R7";
    reg_wr(4'h4, 32'h080);
    reg_rd(4'h4, 32'h101, "R7");
    reg_wr(4'h4, 32'h000);
    reg_rd(4'h4, 32'h101, "R7");

    req = "R8";
    xfer(3, -1, 0, 4, 4'h4, 32'h008, 5, "R8");
    reg_rd(4'h4, 32'h109, "R8");

    req = "R6";
    reg_wr(4'h0, 32'h0);
    xfer(2, 300, 0, -1, 0, 0, 301, "R6");
    reg_rd(4'h4, 32'h109, "R6");

    req = "R10";
    reg_wr(4'h0, 32'd50);
    xfer(5, -1, 0, 10, 4'h0, 32'd5, 12, "R10");
    reg_rd(4'h4, 32'h129, "R10");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule